// File: doc/BRIEF.md
# Six-Byte Checksum Group Encoder

This block turns groups of six data bytes into eight-byte codewords for storage in one-time-programmable fuse arrays that use a three-of-four coding scheme. Each codeword keeps the six data bytes as they are and adds two check bytes. The first check byte is the bitwise XOR of the data. The second is a checksum in which the set-bit count of each data byte is multiplied by that byte's position plus one, and the products are added together.

A group enters on a valid/ready port as a 48-bit vector with a six-bit byte-present mask. It leaves on a valid/ready port as two 32-bit words. A group that lacks any of its six bytes is an invalid request. The block consumes such a group, drops it, and raises a one-cycle reject pulse. The datapath has two register stages. It accepts one group per cycle and delivers each result a fixed two cycles after acceptance unless the output is stalled.

Top module: `grp6_encoder`

## Requirements
- R1: Input byte i occupies in_data[8i+7:8i]. Output bytes 0..5 equal data bytes 0..5 unchanged. Bytes 0..3 fill out_word0 with byte 0 in bits 7:0. Bytes 4 and 5 fill out_word1 bits 7:0 and 15:8.
- R2: out_word1 bits 23:16 hold the XOR of the six data bytes.
- R3: out_word1 bits 31:24 hold the sum over i=0..5 of (i+1) times the set-bit count of data byte i, truncated to 8 bits. Its largest value is 168, reached when every data bit is set.
- R4: A group is complete only when in_keep is 6'b111111, where bit i marks byte i as present. An accepted group with any other mask produces no output word pair. In the cycle after its acceptance grp_reject is 1. In all other cycles grp_reject is 0.
- R5: Every accepted complete group produces exactly one word pair. Word pairs come out in the order in which the groups were accepted.
- R6: When out_ready is held high, a group accepted in one cycle has out_valid low in the next cycle and high in the cycle after that. In that condition in_ready stays high, so one group can be accepted every cycle.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0. In the following cycle out_valid stays 1 and both output words keep their values.
- R8: While rst_n is low, out_valid and grp_reject are 0 and no group is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An input group is offered |
| in_ready | output | 1 | The block takes the offered group in this cycle |
| in_data | input | 48 | Six data bytes, byte 0 in the low bits |
| in_keep | input | 6 | Byte-present mask, one bit per data byte |
| out_valid | output | 1 | A codeword is presented |
| out_ready | input | 1 | The consumer takes the codeword in this cycle |
| out_word0 | output | 32 | Codeword bytes 0..3 |
| out_word1 | output | 32 | Codeword bytes 4..7 (data 4, data 5, parity, checksum) |
| grp_reject | output | 1 | One-cycle pulse after an incomplete group was consumed |

## Verification
The assertions assume that the consumer follows valid/ready and that in_keep is meaningful whenever in_valid is high. They do not assume that the producer holds its data steady while it waits. The stimulus keeps each offered group and its mask unchanged until in_ready takes it. Incomplete masks appear only in the pseudo-random phase. The bench varies out_ready so that stalls occur both with the first stage full and with it empty. One phase holds out_ready high throughout, so that the latency and back-to-back throughput claims are checked under the condition they are stated for.

// File: rtl/grp6_enc_pkg.sv
package grp6_enc_pkg;
  localparam int GRP_BYTES = 6;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int OUT_BYTES = GRP_BYTES + 2;
  localparam int GRP_W     = GRP_BYTES * BYTE_W;
  localparam int OUT_W     = OUT_BYTES * BYTE_W;
  localparam int CNT_W     = $clog2(BYTE_W + 1);
  localparam int CHK_MAX   = (GRP_BYTES * (GRP_BYTES + 1) / 2) * BYTE_W;

  typedef logic [BYTE_W-1:0]                  byte_t;
  typedef logic [GRP_W-1:0]                   grp_t;
  typedef logic [GRP_BYTES-1:0]               keep_t;
  typedef logic [GRP_BYTES-1:0][CNT_W-1:0]    cnt_vec_t;
  typedef logic [WORD_W-1:0]                  word_t;
endpackage

// File: rtl/grp6_rst_sync.sv
module grp6_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/grp6_popcnt.sv
module grp6_popcnt #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int b = 0; b < W; b++) begin
      count_o = count_o + CW'(bits_i[b]);
    end
  end
endmodule

// File: rtl/grp6_front.sv
module grp6_front
  import grp6_enc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv_i,
  input  logic     take_i,
  input  grp_t     data_i,
  output logic     vld_o,
  output grp_t     data_o,
  output byte_t    par_o,
  output cnt_vec_t cnt_o
);
  byte_t    par_c;
  cnt_vec_t cnt_c;
  logic     vld_d, vld_q;
  logic     load_en;

  // per-byte set-bit counts
  for (genvar g = 0; g < GRP_BYTES; g++) begin : g_cnt
    grp6_popcnt #(.W(BYTE_W), .CW(CNT_W)) u_pc (
      .bits_i (data_i[g*BYTE_W +: BYTE_W]),
      .count_o(cnt_c[g])
    );
  end

  // XOR across the six bytes
  always_comb begin
    par_c = '0;
    for (int i = 0; i < GRP_BYTES; i++) begin
      par_c = par_c ^ data_i[i*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    vld_d   = adv_i ? take_i : vld_q;
    load_en = adv_i && take_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      data_o <= data_i;
      par_o  <= par_c;
      cnt_o  <= cnt_c;
    end
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/grp6_back.sv
module grp6_back
  import grp6_enc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv_i,
  input  logic     vld_i,
  input  grp_t     data_i,
  input  byte_t    par_i,
  input  cnt_vec_t cnt_i,
  output logic     vld_o,
  output word_t    w0_o,
  output word_t    w1_o
);
  byte_t             chk_c;
  logic [OUT_W-1:0]  pack_c;
  logic              vld_d, vld_q;
  logic              load_en;

  // position-weighted sum of bit counts, 8-bit wrap
  always_comb begin
    chk_c = '0;
    for (int i = 0; i < GRP_BYTES; i++) begin
      chk_c = chk_c + BYTE_W'(32'(cnt_i[i]) * (i + 1));
    end
  end

  always_comb begin
    pack_c  = {chk_c, par_i, data_i};
    vld_d   = adv_i ? vld_i : vld_q;
    load_en = adv_i && vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      w0_o <= pack_c[WORD_W-1:0];
      w1_o <= pack_c[2*WORD_W-1:WORD_W];
    end
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/grp6_encoder.sv
module grp6_encoder
  import grp6_enc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [GRP_W-1:0]     in_data,
  input  logic [GRP_BYTES-1:0] in_keep,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_W-1:0]    out_word0,
  output logic [WORD_W-1:0]    out_word1,
  output logic                 grp_reject
);
  logic     rst_n_sync;
  logic     adv;
  logic     accept;
  logic     complete;
  logic     take;
  logic     rej_d, rej_q;
  logic     s1_vld;
  grp_t     s1_data;
  byte_t    s1_par;
  cnt_vec_t s1_cnt;
  logic     s2_vld;

  grp6_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  always_comb begin
    adv      = !s2_vld || out_ready;
    in_ready = adv && rst_n_sync;
    accept   = in_valid && in_ready;
    complete = &in_keep;
    take     = accept && complete;
    rej_d    = accept && !complete;
  end

  grp6_front u_front (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .adv_i (adv),
    .take_i(take),
    .data_i(in_data),
    .vld_o (s1_vld),
    .data_o(s1_data),
    .par_o (s1_par),
    .cnt_o (s1_cnt)
  );

  grp6_back u_back (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .adv_i (adv),
    .vld_i (s1_vld),
    .data_i(s1_data),
    .par_i (s1_par),
    .cnt_i (s1_cnt),
    .vld_o (s2_vld),
    .w0_o  (out_word0),
    .w1_o  (out_word1)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rej_q <= 1'b0;
    end else begin
      rej_q <= rej_d;
    end
  end

  assign out_valid  = s2_vld;
  assign grp_reject = rej_q;
endmodule

// File: rtl/grp6_encoder_chk.sv
module grp6_encoder_chk
  import grp6_enc_pkg::*;
(
  input logic                 clk,
  input logic                 rst_q_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [GRP_BYTES-1:0] in_keep,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [WORD_W-1:0]    out_word0,
  input logic [WORD_W-1:0]    out_word1,
  input logic                 grp_reject
);
  logic [BYTE_W-1:0] data_xor;
  always_comb begin
    data_xor = out_word0[7:0] ^ out_word0[15:8] ^ out_word0[23:16] ^
               out_word0[31:24] ^ out_word1[7:0] ^ out_word1[15:8];
  end

  AST_PARITY_BYTE: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> out_word1[23:16] == data_xor); // R2

  AST_CHECKSUM_BOUND: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> 32'(out_word1[31:24]) <= CHK_MAX); // R3

  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_ready && !(&in_keep)) |=> grp_reject); // R4

  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    grp_reject |-> $past(in_valid && in_ready && !(&in_keep))); // R4

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_ready && (&in_keep)) |-> ##2 out_valid); // R6

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

  AST_STALL_HOLDS_WORDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_word0) && $stable(out_word1)); // R7
endmodule

bind grp6_encoder grp6_encoder_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_n_sync),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_keep   (in_keep),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word0 (out_word0),
  .out_word1 (out_word1),
  .grp_reject(grp_reject)
);

// File: tb/grp6_encoder_bench.sv
`timescale 1ns/1ps
module grp6_encoder_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [47:0] in_data;
  logic [5:0]  in_keep;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_word0;
  logic [31:0] out_word1;
  logic        grp_reject;

  grp6_encoder u_grp6_encoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_keep   (in_keep),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word0 (out_word0),
    .out_word1 (out_word1),
    .grp_reject(grp_reject)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int          n_checks = 0;
  int          n_fails  = 0;
  bit          finished = 0;
  logic [63:0] exp_q[$];
  bit          exp_rej  = 0;
  bit          prev_stall = 0;
  logic [31:0] prev_w0, prev_w1;
  logic [31:0] rnd = 32'h1234_5678;

  function automatic logic [31:0] next_rnd(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // expected codeword, computed from R1..R3
  function automatic logic [63:0] encode(input logic [47:0] d);
    logic [7:0] px;
    int         sum;
    px  = '0;
    sum = 0;
    for (int i = 0; i < 6; i++) begin
      int c;
      c = 0;
      for (int b = 0; b < 8; b++) c += int'(d[i*8+b]);
      px  = px ^ d[i*8 +: 8];
      sum = sum + (i + 1) * c;
    end
    return {sum[7:0], px, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [47:0] d, input logic [5:0] k,
                     input bit r, output bit acc);
    logic [63:0] e;
    @(negedge clk);
    in_valid = v; in_data = d; in_keep = k; out_ready = r;
    #1;
    chk(grp_reject === exp_rej, "R4 reject pulse", 64'(grp_reject), 64'(exp_rej));
    if (prev_stall) begin
      chk(out_valid === 1'b1 && out_word0 === prev_w0 && out_word1 === prev_w1,
          "R7 stalled output held", {out_word1, out_word0}, {prev_w1, prev_w0});
    end
    if (out_valid && !out_ready) begin
      chk(in_ready === 1'b0, "R7 input blocked during stall", 64'(in_ready), 64'd0);
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected word pair", {out_word1, out_word0}, 64'd0);
      end else begin
        e = exp_q.pop_front();
        chk({out_word1[15:0], out_word0} === e[47:0], "R1 data bytes",
            {16'd0, out_word1[15:0], out_word0}, {16'd0, e[47:0]});
        chk(out_word1[23:16] === e[55:48], "R2 parity byte",
            64'(out_word1[23:16]), 64'(e[55:48]));
        chk(out_word1[31:24] === e[63:56], "R3 checksum byte",
            64'(out_word1[31:24]), 64'(e[63:56]));
      end
    end
    acc     = v && (in_ready === 1'b1);
    exp_rej = acc && (k != 6'h3F);
    if (acc && k == 6'h3F) exp_q.push_back(encode(d));
    prev_stall = out_valid && !out_ready;
    prev_w0    = out_word0;
    prev_w1    = out_word1;
  endtask

  task automatic send(input logic [47:0] d, input logic [5:0] k, input int rdy_mode);
    bit acc;
    bit r;
    do begin
      rnd = next_rnd(rnd);
      r   = (rdy_mode == 0) ? 1'b1 : (rnd[1:0] != 2'b00);
      cyc(1'b1, d, k, r, acc);
    end while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cyc(1'b0, 48'd0, 6'h00, 1'b1, acc);
  endtask

  initial begin
    bit          acc;
    logic [47:0] d;
    logic [5:0]  k;
    in_valid = 0; in_data = '0; in_keep = '0; out_ready = 1'b1;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_keep = 6'h3F;
      #1;
      chk(out_valid === 1'b0 && grp_reject === 1'b0, "R8 outputs quiet in reset",
          {62'd0, out_valid, grp_reject}, 64'd0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R6: latency with out_ready held high
    send(48'hDEAD_BEEF_0123, 6'h3F, 0);
    cyc(1'b0, 48'd0, 6'h00, 1'b1, acc);
    chk(out_valid === 1'b0, "R6 no result one cycle after accept", 64'(out_valid), 64'd0);
    cyc(1'b0, 48'd0, 6'h00, 1'b1, acc);
    chk(out_valid === 1'b1, "R6 result two cycles after accept", 64'(out_valid), 64'd1);

    // R6: back-to-back throughput
    for (int n = 0; n < 64; n++) begin
      rnd = next_rnd(rnd);
      d   = {rnd[15:0], rnd};
      cyc(1'b1, d, 6'h3F, 1'b1, acc);
      chk(acc, "R6 group accepted every cycle", 64'(acc), 64'd1);
    end
    idle(3);

    // R1..R3: each byte position swept over all values, under back-pressure
    for (int p = 0; p < 6; p++) begin
      for (int v = 0; v < 256; v++) begin
        rnd = next_rnd(rnd);
        d   = {rnd[15:0], rnd};
        d[p*8 +: 8] = 8'(v);
        send(d, 6'h3F, 1);
      end
    end

    // R3: extremes, including maximum checksum 168
    send(48'h0, 6'h3F, 1);
    send({6{8'hFF}}, 6'h3F, 1);
    send({3{16'hAA55}}, 6'h3F, 1);
    send(48'h8000_0000_0001, 6'h3F, 0);

    // R4/R5: mixed complete and incomplete groups
    for (int n = 0; n < 600; n++) begin
      rnd = next_rnd(rnd);
      d   = {rnd[31:16], rnd ^ 32'h5A5A_A5A5};
      k   = (n % 3 == 0) ? (rnd[5:0] & 6'b111110) : 6'h3F;
      if (n % 5 == 1) k = 6'b011111;
      send(d, k, 1);
    end
    idle(8);
    chk(exp_q.size() == 0, "R5 every complete group delivered",
        64'(exp_q.size()), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule